// File: doc/BRIEF.md
# Profile-Modulated Dual-Channel Direct Digital Synthesizer

This block generates two digital cosine waveforms from one shared system clock. Each channel keeps a 32-bit phase accumulator, adds its own 14-bit phase offset, turns the top phase bits into a cosine value through a small quarter-wave table, scales it with its own 10-bit amplitude factor, and presents a 10-bit offset-binary sample for a DAC. Both accumulators advance on the same edges, so their phases stay in a fixed relation.

The host writes control words through a simple word-wide write port into shadow (buffer) registers. Nothing reaches the running datapath until the update strobe, which moves every shadow word of every channel into the working registers on the same edge. Each channel also owns a table of sixteen preset words. A per-channel modulation mode makes the 4-bit profile input select one preset as the channel's frequency word, phase offset or amplitude, which gives up to 16-level FSK, PSK or ASK without any further register traffic. A clock divided by four from the system clock is produced for synchronising external logic.

Top module: `dual_dds_core`

## Requirements
- R1: On every system clock edge outside reset, each channel's 32-bit accumulator adds the channel's effective frequency word modulo 2^32; both channels step on the same edges.
- R2: The 14-bit phase of a channel is accumulator bits [31:18] plus the effective phase offset, modulo 2^14; its top 8 bits select the cosine value.
- R3: For an 8-bit phase p the cosine value is 511*cos(2*pi*(p+0.5)/256), rounded to the nearest integer with halves away from zero, rebuilt from a 64-entry quarter-wave table by folding.
- R4: The scaled value is floor(cosine * A / 1024), where A is the 10-bit effective amplitude; A = 0 gives a scaled value of 0.
- R5: Channel c drives dac_data[10c+9:10c] with the scaled value plus 512 (offset binary); the sample appears 3 clocks after the edge that latched the accumulator and settings it uses.
- R6: Writes land in shadow registers and take effect only on an edge with io_update high; a write in the same cycle as io_update stays in the shadow copy. Address map per channel (wr_chan selects): 0 frequency word, 1 phase offset in bits [13:0], 2 amplitude in bits [9:0], 3 control, 16+k preset k (32 bits); addresses 4 to 15 are ignored.
- R7: Control bits [1:0] set the mode: 0 none, 1 the preset chosen by profile replaces the frequency word, 2 preset bits [13:0] replace the phase offset, 3 preset bits [9:0] replace the amplitude; the other two settings keep their base values, and the profile input acts without an update.
- R8: Control bit 2 is a clear request: on an update edge where the shadow copy of this bit is 1, that channel's accumulator loads 0 instead of stepping.
- R9: sync_clk is the system clock divided by 4: after the k-th edge following reset release it equals bit 1 of k mod 4.
- R10: Synchronous active-high reset zeroes accumulators, shadow and working registers and the pipeline, so both samples read 512 and sync_clk reads 0.
- R11: Two channels given equal settings and cleared on the same update produce identical samples from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe into the shadow registers |
| wr_chan | input | 1 | Channel receiving the write |
| wr_addr | input | 5 | Register address (see R6) |
| wr_data | input | 32 | Write data |
| io_update | input | 1 | Moves all shadow words into the working registers |
| profile | input | 4 | Preset index for modulation |
| dac_data | output | 20 | Two 10-bit offset-binary samples, channel 0 in the low bits |
| sync_clk | output | 1 | System clock divided by 4 |

## Verification
A frequency word that advances the 8-bit lookup phase by exactly one step per clock walks the whole cosine circle, which separates folding, sign and rounding faults from accumulator faults; a second channel with a slower word and a phase offset shows that offsets and amplitudes are kept per channel. Profile sweeps under each modulation mode tell frequency, phase and amplitude substitution apart, and an amplitude preset of 0 and of 1023 pins the scaling ends. Writes without an update, a write coinciding with the update, a maximum phase offset that wraps, and a joint clear of both channels separate the buffering, wrap and lockstep behaviour from the plain running tone.

// File: rtl/dds_pkg.sv
package dds_pkg;

    localparam int FTW_W       = 32;
    localparam int POW_W       = 14;
    localparam int ASF_W       = 10;
    localparam int OUT_W       = 10;
    localparam int PROF_W      = 4;
    localparam int NUM_PROF    = 1 << PROF_W;
    localparam int ADDR_W      = PROF_W + 1;
    localparam int LUT_W       = 8;
    localparam int QIDX_W      = LUT_W - 2;
    localparam int QN          = 1 << QIDX_W;
    localparam int MAG_W       = OUT_W - 1;

    localparam logic [ADDR_W-1:0] ADR_FREQ  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_PHASE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADR_AMP   = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ADR_CTRL  = ADDR_W'(3);
    localparam int CTRL_CLR_BIT = 2;

    typedef enum logic [1:0] {
        MOD_NONE  = 2'd0,
        MOD_FREQ  = 2'd1,
        MOD_PHASE = 2'd2,
        MOD_AMP   = 2'd3
    } mod_mode_e;

    typedef struct packed {
        logic [FTW_W-1:0] ftw;
        logic [POW_W-1:0] pow;
        logic [ASF_W-1:0] asf;
        mod_mode_e        mode;
    } chan_regs_t;

    typedef struct packed {
        logic [FTW_W-1:0] ftw;
        logic [POW_W-1:0] pow;
        logic [ASF_W-1:0] asf;
    } chan_eff_t;

    typedef struct packed {
        logic [LUT_W-1:0] phase;
        logic [ASF_W-1:0] asf;
    } stage_a_t;

    typedef struct packed {
        logic [OUT_W-1:0] cosv;
        logic [ASF_W-1:0] asf;
    } stage_b_t;

    // Quarter-wave cosine magnitudes sampled at half-step offsets.
    function automatic logic [QN*MAG_W-1:0] build_quarter_table();
        logic [QN*MAG_W-1:0] tab;
        real two_pi;
        real ang;
        tab    = '0;
        two_pi = 6.283185307179586;
        for (int i = 0; i < QN; i++) begin
            ang = two_pi * (real'(i) + 0.5) / real'(4 * QN);
            tab[i*MAG_W +: MAG_W] =
                MAG_W'($rtoi(real'((1 << MAG_W) - 1) * $cos(ang) + 0.5));
        end
        return tab;
    endfunction

    function automatic logic [OUT_W-1:0] to_offset_binary(logic [OUT_W-1:0] v);
        return {~v[OUT_W-1], v[OUT_W-2:0]};
    endfunction

endpackage

// File: rtl/dds_regbank.sv
module dds_regbank
    import dds_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              io_update,
    input  logic [PROF_W-1:0] profile,
    output chan_eff_t         eff,
    output logic              clr_now
);

    chan_regs_t       shadow_q;
    chan_regs_t       work_q;
    logic             shadow_clr_q;
    logic [FTW_W-1:0] shadow_pre_q [NUM_PROF];
    logic [FTW_W-1:0] work_pre_q   [NUM_PROF];
    logic [FTW_W-1:0] sel_preset;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q     <= '0;
            work_q       <= '0;
            shadow_clr_q <= 1'b0;
            for (int k = 0; k < NUM_PROF; k++) begin
                shadow_pre_q[k] <= '0;
                work_pre_q[k]   <= '0;
            end
        end else begin
            if (io_update) begin
                work_q <= shadow_q;
                for (int k = 0; k < NUM_PROF; k++) begin
                    work_pre_q[k] <= shadow_pre_q[k];
                end
            end
            if (wr_en) begin
                if (wr_addr[ADDR_W-1]) begin
                    shadow_pre_q[wr_addr[PROF_W-1:0]] <= wr_data;
                end else begin
                    case (wr_addr)
                        ADR_FREQ:  shadow_q.ftw <= wr_data;
                        ADR_PHASE: shadow_q.pow <= wr_data[POW_W-1:0];
                        ADR_AMP:   shadow_q.asf <= wr_data[ASF_W-1:0];
                        ADR_CTRL: begin
                            shadow_q.mode <= mod_mode_e'(wr_data[1:0]);
                            shadow_clr_q  <= wr_data[CTRL_CLR_BIT];
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign sel_preset = work_pre_q[profile];
    assign clr_now    = io_update & shadow_clr_q;

    always_comb begin
        eff.ftw = work_q.ftw;
        eff.pow = work_q.pow;
        eff.asf = work_q.asf;
        unique case (work_q.mode)
            MOD_FREQ:  eff.ftw = sel_preset;
            MOD_PHASE: eff.pow = sel_preset[POW_W-1:0];
            MOD_AMP:   eff.asf = sel_preset[ASF_W-1:0];
            default: ;
        endcase
    end

    // R6: working copy moves only on the update strobe
    assert_hold_without_update_R6: assert property (@(posedge clk) disable iff (rst)
        !io_update |=> $stable(work_q));

    // R6: working copy equals the shadow copy seen at the update edge
    assert_load_on_update_R6: assert property (@(posedge clk) disable iff (rst)
        io_update |=> (work_q == $past(shadow_q)));

endmodule

// File: rtl/dds_cos_lut.sv
module dds_cos_lut
    import dds_pkg::*;
(
    input  logic [LUT_W-1:0] phase,
    output logic [OUT_W-1:0] cosv
);

    localparam logic [QN*MAG_W-1:0] QTAB = build_quarter_table();

    logic [1:0]        quad;
    logic [QIDX_W-1:0] idx;
    logic [MAG_W-1:0]  mag;
    logic              negate;

    always_comb begin
        quad   = phase[LUT_W-1 -: 2];
        idx    = quad[0] ? ~phase[QIDX_W-1:0] : phase[QIDX_W-1:0];
        mag    = QTAB[idx*MAG_W +: MAG_W];
        negate = quad[0] ^ quad[1];
        cosv   = negate ? (~{1'b0, mag} + OUT_W'(1)) : {1'b0, mag};
    end

endmodule

// File: rtl/dds_channel.sv
module dds_channel
    import dds_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  chan_eff_t        eff,
    input  logic             clr_now,
    output logic [OUT_W-1:0] sample
);

    localparam int PROD_W = OUT_W + ASF_W + 1;

    logic [FTW_W-1:0]         acc_q;
    logic [POW_W-1:0]         phase_full;
    stage_a_t                 sa_q;
    stage_b_t                 sb_q;
    logic [OUT_W-1:0]         cos_val;
    logic signed [PROD_W-1:0] prod;
    logic [OUT_W-1:0]         scaled;
    logic [OUT_W-1:0]         sample_q;
    logic                     unused_phase_low;
    logic                     unused_prod_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (clr_now) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_q + eff.ftw;
        end
    end

    assign phase_full       = acc_q[FTW_W-1 -: POW_W] + eff.pow;
    assign unused_phase_low = ^phase_full[POW_W-LUT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sa_q <= '0;
        end else begin
            sa_q.phase <= phase_full[POW_W-1 -: LUT_W];
            sa_q.asf   <= eff.asf;
        end
    end

    dds_cos_lut u_lut (
        .phase (sa_q.phase),
        .cosv  (cos_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sb_q <= '0;
        end else begin
            sb_q.cosv <= cos_val;
            sb_q.asf  <= sa_q.asf;
        end
    end

    assign prod             = $signed(sb_q.cosv) * $signed({1'b0, sb_q.asf});
    assign scaled           = prod[ASF_W +: OUT_W];
    assign unused_prod_bits = ^{prod[PROD_W-1], prod[ASF_W-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q <= to_offset_binary('0);
        end else begin
            sample_q <= to_offset_binary(scaled);
        end
    end

    assign sample = sample_q;

    // R1: accumulator steps by the effective word when not cleared
    assert_acc_step_R1: assert property (@(posedge clk) disable iff (rst)
        !clr_now |=> (acc_q == $past(acc_q + eff.ftw)));

    // R8: clear request restarts the phase at zero
    assert_acc_clear_R8: assert property (@(posedge clk) disable iff (rst)
        clr_now |=> (acc_q == '0));

    // R4: zero amplitude gives mid-scale output
    assert_zero_amp_midscale_R4: assert property (@(posedge clk) disable iff (rst)
        (sb_q.asf == '0) |=> (sample_q == {1'b1, {(OUT_W-1){1'b0}}}));

    // R10: reset leaves the accumulator at zero
    assert_reset_acc_R10: assert property (@(posedge clk)
        rst |=> (acc_q == '0));

endmodule

// File: rtl/dds_sync_div.sv
module dds_sync_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic sync_clk
);

    localparam int CW = $clog2(DIV);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign sync_clk = cnt_q[CW-1];

    // R9: each level of the divided clock lasts at least two system clocks
    assert_sync_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (sync_clk != $past(sync_clk)) |=> $stable(sync_clk));

endmodule

// File: rtl/dual_dds_core.sv
module dual_dds_core
    import dds_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int SYNC_DIV = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     wr_chan,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [31:0]              wr_data,
    input  logic                     io_update,
    input  logic [PROF_W-1:0]        profile,
    output logic [NUM_CH*OUT_W-1:0]  dac_data,
    output logic                     sync_clk
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        chan_eff_t eff;
        logic      clr_now;
        logic      ch_wr;

        assign ch_wr = wr_en && (wr_chan == 1'(c));

        dds_regbank u_regs (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (ch_wr),
            .wr_addr   (wr_addr),
            .wr_data   (wr_data),
            .io_update (io_update),
            .profile   (profile),
            .eff       (eff),
            .clr_now   (clr_now)
        );

        dds_channel u_chan (
            .clk     (clk),
            .rst     (rst),
            .eff     (eff),
            .clr_now (clr_now),
            .sample  (dac_data[c*OUT_W +: OUT_W])
        );
    end

    dds_sync_div #(.DIV(SYNC_DIV)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sync_clk (sync_clk)
    );

endmodule

// File: tb/dual_dds_core_tb.sv
`timescale 1ns/1ps
module dual_dds_core_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic        wr_chan;
    logic [4:0]  wr_addr;
    logic [31:0] wr_data;
    logic        io_update;
    logic [3:0]  profile;
    logic [19:0] dac_data;
    logic        sync_clk;

    always #2 clk = ~clk;

    dual_dds_core dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_chan(wr_chan),
        .wr_addr(wr_addr), .wr_data(wr_data), .io_update(io_update),
        .profile(profile), .dac_data(dac_data), .sync_clk(sync_clk)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R1 R2 R3 R4 R5";

    // behavioural reference state
    bit [31:0] b_ftw [2], a_ftw [2];
    bit [13:0] b_pow [2], a_pow [2];
    bit [9:0]  b_asf [2], a_asf [2];
    bit [1:0]  b_mode[2], a_mode[2];
    bit        b_clr [2];
    bit [31:0] b_pre [2][16], a_pre [2][16];
    bit [31:0] m_acc [2];
    int        sync_k;
    int        q0[$];
    int        q1[$];

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int cos_ref(int p);
        real v;
        v = 511.0 * $cos(6.283185307179586 * (real'(p) + 0.5) / 256.0);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    function automatic bit [31:0] eff_ftw(int ch);
        return (a_mode[ch] == 2'd1) ? a_pre[ch][profile] : a_ftw[ch];
    endfunction

    function automatic int exp_sample(int ch);
        int pw, asf, ph, c, s;
        pw  = (a_mode[ch] == 2'd2) ? int'(a_pre[ch][profile] & 32'h3FFF) : int'(a_pow[ch]);
        asf = (a_mode[ch] == 2'd3) ? int'(a_pre[ch][profile] & 32'h3FF) : int'(a_asf[ch]);
        ph  = (int'(m_acc[ch] >> 18) + pw) % 16384;
        c   = cos_ref(ph / 64);
        s   = (c * asf) >>> 10;
        return s + 512;
    endfunction

    task automatic model_reset();
        for (int ch = 0; ch < 2; ch++) begin
            b_ftw[ch] = 0; a_ftw[ch] = 0; b_pow[ch] = 0; a_pow[ch] = 0;
            b_asf[ch] = 0; a_asf[ch] = 0; b_mode[ch] = 0; a_mode[ch] = 0;
            b_clr[ch] = 0; m_acc[ch] = 0;
            for (int k = 0; k < 16; k++) begin
                b_pre[ch][k] = 0; a_pre[ch][k] = 0;
            end
        end
        sync_k = 0;
        q0.delete(); q1.delete();
        q0.push_back(512); q0.push_back(512);
        q1.push_back(512); q1.push_back(512);
    endtask

    task automatic model_step();
        for (int ch = 0; ch < 2; ch++) begin
            if (io_update && b_clr[ch]) m_acc[ch] = 0;
            else m_acc[ch] = m_acc[ch] + eff_ftw(ch);
            if (io_update) begin
                a_ftw[ch] = b_ftw[ch]; a_pow[ch] = b_pow[ch];
                a_asf[ch] = b_asf[ch]; a_mode[ch] = b_mode[ch];
                for (int k = 0; k < 16; k++) a_pre[ch][k] = b_pre[ch][k];
            end
            if (wr_en && int'(wr_chan) == ch) begin
                if (wr_addr >= 5'd16) b_pre[ch][wr_addr - 5'd16] = wr_data;
                else case (wr_addr)
                    5'd0: b_ftw[ch] = wr_data;
                    5'd1: b_pow[ch] = wr_data[13:0];
                    5'd2: b_asf[ch] = wr_data[9:0];
                    5'd3: begin b_mode[ch] = wr_data[1:0]; b_clr[ch] = wr_data[2]; end
                    default: ;
                endcase
            end
        end
        sync_k++;
    endtask

    // one clock: reference and design compared after every edge
    task automatic tick();
        q0.push_back(exp_sample(0));
        q1.push_back(exp_sample(1));
        model_step();
        @(posedge clk);
        @(negedge clk);
        check({cur_req, " ch0"}, int'(dac_data[9:0]), q0.pop_front());
        check({cur_req, " ch1"}, int'(dac_data[19:10]), q1.pop_front());
        check("R9 sync_clk", int'(sync_clk), (sync_k >> 1) & 1);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(bit ch, bit [4:0] addr, bit [31:0] data);
        wr_en = 1'b1; wr_chan = ch; wr_addr = addr; wr_data = data;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic upd();
        io_update = 1'b1;
        tick();
        io_update = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got 0 expected 1 (run completion)");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_chan = 1'b0; wr_addr = '0;
        wr_data = '0; io_update = 1'b0; profile = '0;
        repeat (3) @(negedge clk);
        check("R10 reset ch0", int'(dac_data[9:0]), 512);
        check("R10 reset ch1", int'(dac_data[19:10]), 512);
        check("R10 reset sync", int'(sync_clk), 0);
        model_reset();
        rst = 1'b0;

        // buffered writes: no change until update
        cur_req = "R6 buffered";
        wr(0, 5'd0, 32'h0100_0000);
        wr(0, 5'd2, 32'd1023);
        wr(1, 5'd0, 32'h0080_0000);
        wr(1, 5'd1, 32'h0000_1000);
        wr(1, 5'd2, 32'd600);
        wr(0, 5'd5, 32'hFFFF_FFFF);
        run(4);
        check("R6 no update ch0", int'(dac_data[9:0]), 512);
        check("R6 no update ch1", int'(dac_data[19:10]), 512);
        upd();

        // full phase walk on ch0, slower tone with offset on ch1
        cur_req = "R1 R2 R3 R4 R5";
        run(300);

        // write coinciding with update stays in the shadow copy
        cur_req = "R6 same-cycle";
        wr_en = 1'b1; wr_chan = 1'b1; wr_addr = 5'd0; wr_data = 32'h0300_0000;
        io_update = 1'b1;
        tick();
        wr_en = 1'b0; io_update = 1'b0;
        run(12);
        upd();
        run(12);

        // frequency presets
        cur_req = "R7 FSK";
        for (int k = 0; k < 4; k++) wr(0, 5'(16 + k), 32'h0040_0000 * (k + 1));
        wr(0, 5'd3, 32'd1);
        upd();
        for (int k = 0; k < 4; k++) begin profile = 4'(k); run(10); end

        // phase presets
        cur_req = "R7 PSK";
        for (int k = 0; k < 16; k++) wr(1, 5'(16 + k), 32'(k * 1024));
        wr(1, 5'd3, 32'd2);
        upd();
        for (int k = 15; k >= 0; k--) begin profile = 4'(k); run(4); end

        // amplitude presets including both ends
        cur_req = "R7 R4 ASK";
        wr(0, 5'd16, 32'd0);
        wr(0, 5'd17, 32'd1023);
        wr(0, 5'd18, 32'd256);
        wr(0, 5'd19, 32'd777);
        wr(0, 5'd3, 32'd3);
        upd();
        for (int k = 0; k < 4; k++) begin profile = 4'(k); run(8); end
        profile = 4'd0;
        run(3);
        check("R4 zero amplitude ch0", int'(dac_data[9:0]), 512);

        // maximum phase offset wraps
        cur_req = "R2 wrap";
        wr(1, 5'd3, 32'd0);
        wr(1, 5'd1, 32'h0000_3FFF);
        upd();
        run(20);

        // joint clear and lockstep
        cur_req = "R8 R11 clear";
        for (int ch = 0; ch < 2; ch++) begin
            wr(1'(ch), 5'd0, 32'h0123_4567);
            wr(1'(ch), 5'd1, 32'd0);
            wr(1'(ch), 5'd2, 32'd900);
            wr(1'(ch), 5'd3, 32'd4);
        end
        upd();
        wr(0, 5'd3, 32'd0);
        wr(1, 5'd3, 32'd0);
        run(2);
        for (int i = 0; i < 20; i++) begin
            tick();
            check("R11 lockstep", int'(dac_data[9:0]), int'(dac_data[19:10]));
        end

        // clear with zero frequency holds phase at zero
        cur_req = "R8 hold";
        wr(0, 5'd0, 32'd0);
        wr(0, 5'd3, 32'd4);
        upd();
        run(6);
        check("R8 held phase ch0", int'(dac_data[9:0]), ((cos_ref(0) * 900) >>> 10) + 512);

        done = 1;
        summary();
        $finish;
    end

endmodule